// File: doc/BRIEF.md
# Touch Controller Serial Command Decoder

This block sits behind the byte shifter of a serial slave port on a touch-sensing controller. On every byte strobe it takes one received byte and updates the byte offered for the next slot. The first byte of an exchange is either a complete one-byte command for the conversion sequencer or the header of a three-byte register frame. A register frame moves one 16-bit word, high byte first, in either direction.

The decoder holds the configuration words, the auxiliary and temperature limit registers and the data-available flags. It sends one-cycle pulses to the conversion sequencer for a full reset, a new function request and a change of the sensing-enable level. Conversion results and the active-function flags come in from the sequencer on input buses and are read through the same register frames. Bit-level shifting, chip-select handling and the conversions themselves are outside this block.

The response is combinational from the frame position: `tx_byte` is the byte the shifter must send in the next byte slot. It is zero whenever the decoder waits for a first byte.

Top module: `touch_serial_decoder`

## Requirements
- R1: A first byte with bit 7 = 1 and bit 1 = 0 is a command. In the cycle after its strobe, `seq_func_req` pulses for one cycle, `seq_func` = bits 6:3, `next_prec` = bit 2 and `sense_en` = NOT bit 0. `seq_sense_chg` pulses only if `sense_en` changed. The next byte is again a first byte.
- R2: A command byte with bit 7 = 1 and bit 1 = 1 pulses `seq_reset` and not `seq_func_req`. Like a low `rst_n` at a clock edge, it restores the defaults: configuration words 0, `sense_en` 0, flags 0, reset-seen 0, high limits 0x0FFF, low limits 0x0000. A low `rst_n` also returns the frame position to the first byte.
- R3: An all-zero first byte changes nothing and leaves the position at the first byte. While the decoder waits for a first byte, `tx_byte` is 0.
- R4: A first byte with bit 7 = 0, non-zero, opens a frame: bits 6:3 address, bit 0 = 1 read. In a read frame the word is captured when the header arrives. After the header `tx_byte` = high byte, after the second byte low byte, after the third 0.
- R5: In a write frame the second byte is the high byte and the third the low byte. The register changes only at the third byte.
- R6: Address 0xC: bits 12:0 timing, bit 13 next precision (shared with R1), bit 14 = 1 stops sensing, bit 15 host mode. It reads back as {host, NOT sense_en, next_prec, timing}. A change of `sense_en` pulses `seq_sense_chg`.
- R7: Address 0xD keeps only the bits of mask 0x0F07.
- R8: Address 0xE holds the interrupt pin function in bits 15:14 and the filter setting in bits 13:0.
- R9: Addresses 0x8 and 0xA are the auxiliary and temperature high limits, default 0x0FFF. Addresses 0x9 and 0xB are the matching low limits, default 0x0000. All four are full 16-bit read/write.
- R10: Writes to addresses 0x0 to 0x7 and 0xF change no register.
- R11: Reading address 0x7 returns the flags OR reset-seen at bit 7 OR `pwrdn_stat` at bit 2. The read then clears flag bits 7:5 and sets reset-seen.
- R12: A `dav_set` bit raised in the same cycle as the clearing read of R11 is kept. Set wins over clear.
- R13: Addresses 0x0 to 0x6 return word n of `conv_bus` (bits 16n+15:16n). Address 0xF returns `func_active`.
- R14: `pd_ctrl` holds bit 1 of the most recent register-frame header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Byte strobe, one cycle per received byte |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Byte to send in the next slot |
| conv_bus | input | 112 | Seven conversion result words, word n at bits 16n+15:16n |
| func_active | input | 16 | One-hot of the running function, read at 0xF |
| dav_set | input | 16 | Flag set pulses from the sequencer |
| pwrdn_stat | input | 1 | Power-down status, status bit 2 |
| seq_reset | output | 1 | Full reset pulse |
| seq_func_req | output | 1 | New function request pulse |
| seq_func | output | 4 | Requested function |
| next_prec | output | 1 | Requested precision |
| seq_sense_chg | output | 1 | Sensing-enable change pulse |
| sense_en | output | 1 | Sensing enabled |
| host_mode | output | 1 | Host-controlled mode |
| timing_cfg | output | 13 | Timing field |
| cfg1_word | output | 16 | Second configuration word |
| pin_func | output | 2 | Interrupt pin function |
| filter_cfg | output | 14 | Filter setting |
| pd_ctrl | output | 1 | Power-down control bit from the last header |

## Verification
A sequencer flag-set pulse can land in the same clock edge as the header of a status read, which clears three of those flags. The bench raises `dav_set` bit 6 for exactly the strobe cycle of a status header. It then checks that the returned word shows the old flags and that the next status read shows bit 6 still set. A third read confirms that only the second read cleared it.

// File: rtl/tsd_pkg.sv
// Shared constants and types of the touch serial decoder.
// Assumes a fixed three-position frame and 4-bit register addresses.
package tsd_pkg;
    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 4;
    localparam int CONV_SLOTS = 7;
    localparam int THR_SLOTS  = 4;

    typedef enum logic [1:0] {
        POS_HDR = 2'd0,
        POS_HI  = 2'd1,
        POS_LO  = 2'd2
    } frame_pos_e;

    localparam logic [ADDR_W-1:0] A_STATUS = 4'h7;
    localparam logic [ADDR_W-1:0] A_THR0   = 4'h8;
    localparam logic [ADDR_W-1:0] A_CFG0   = 4'hC;
    localparam logic [ADDR_W-1:0] A_CFG1   = 4'hD;
    localparam logic [ADDR_W-1:0] A_CFG2   = 4'hE;
    localparam logic [ADDR_W-1:0] A_FUNC   = 4'hF;

    localparam logic [WORD_W-1:0] CFG1_MASK  = 16'h0F07;
    localparam logic [WORD_W-1:0] THR_HI_DEF = 16'h0FFF;
    localparam logic [WORD_W-1:0] THR_LO_DEF = 16'h0000;
    localparam logic [WORD_W-1:0] TEST_FLAGS = 16'h00E0;
endpackage

// File: rtl/tsd_frame_ctrl.sv
// Frame position tracker and first-byte decoder.
// Splits first bytes into commands and register frame headers, captures the
// read word at the header, assembles write words and drives the reply byte.
// Assumes rx_valid is one cycle per byte; rd_word is combinational from rd_addr.
module tsd_frame_ctrl
    import tsd_pkg::*;
#(
    parameter int WORD_W_P = WORD_W,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic [WORD_W_P-1:0] rd_word,
    output logic [ADDR_W_P-1:0] rd_addr,
    output logic                status_rd,
    output logic                cmd_en,
    output logic                cmd_rst,
    output logic [3:0]          cmd_func,
    output logic                cmd_prec,
    output logic                cmd_stop,
    output logic                wr_en,
    output logic [ADDR_W_P-1:0] wr_addr,
    output logic [WORD_W_P-1:0] wr_data,
    output logic [7:0]          tx_byte,
    output logic                pd_ctrl
);
    localparam int BYTE_W = WORD_W_P / 2;

    frame_pos_e          pos_q;
    logic                is_rd_q;
    logic [ADDR_W_P-1:0] addr_q;
    logic [BYTE_W-1:0]   hi_q;
    logic [WORD_W_P-1:0] shadow_q;
    logic                pd_q;
    logic                hdr_stb;
    logic                frame_open;

    // First-byte classification
    always_comb begin
        hdr_stb    = rx_valid && (pos_q == POS_HDR);
        cmd_en     = hdr_stb && rx_byte[7];
        frame_open = hdr_stb && !rx_byte[7] && (rx_byte != 8'h00);
        rd_addr    = rx_byte[6:3];
        status_rd  = frame_open && rx_byte[0] && (rd_addr == A_STATUS);
        cmd_rst    = rx_byte[1];
        cmd_func   = rx_byte[6:3];
        cmd_prec   = rx_byte[2];
        cmd_stop   = rx_byte[0];
    end

    // Write commit at the third byte of a write frame
    always_comb begin
        wr_en   = rx_valid && (pos_q == POS_LO) && !is_rd_q;
        wr_addr = addr_q;
        wr_data = {hi_q, rx_byte};
    end

    // Reply byte for the next slot
    always_comb begin
        tx_byte = 8'h00;
        if (is_rd_q && pos_q == POS_HI) tx_byte = shadow_q[WORD_W_P-1:BYTE_W];
        if (is_rd_q && pos_q == POS_LO) tx_byte = shadow_q[BYTE_W-1:0];
    end

    assign pd_ctrl = pd_q;

    // Frame position and header capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= POS_HDR;
            is_rd_q  <= 1'b0;
            addr_q   <= '0;
            hi_q     <= '0;
            shadow_q <= '0;
            pd_q     <= 1'b0;
        end else if (rx_valid) begin
            case (pos_q)
                POS_HDR: begin
                    if (frame_open) begin
                        pos_q   <= POS_HI;
                        addr_q  <= rd_addr;
                        is_rd_q <= rx_byte[0];
                        pd_q    <= rx_byte[1];
                        if (rx_byte[0]) shadow_q <= rd_word;
                    end
                end
                POS_HI: begin
                    hi_q  <= rx_byte;
                    pos_q <= POS_LO;
                end
                default: pos_q <= POS_HDR;
            endcase
        end
    end

    // R1: a command leaves the decoder waiting for a first byte
    a_r1_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && pos_q == POS_HDR && rx_byte[7]) |=> (pos_q == POS_HDR));
    // R3: a zero first byte keeps the idle position
    a_r3_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && pos_q == POS_HDR && rx_byte == 8'h00) |=> (pos_q == POS_HDR));
    // R4: the captured read word holds until the next strobe
    a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid) |=> $stable(shadow_q));
    // R5: no register write while a header is taken
    a_r5_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && pos_q == POS_HDR) |-> !wr_en);
endmodule

// File: rtl/tsd_regbank.sv
// Register bank of the touch serial decoder.
// Holds configuration, limit registers, flags and sequencer pulses; provides
// the combinational read word for an address. Assumes commands and writes
// never coincide (they come from different frame positions).
module tsd_regbank
    import tsd_pkg::*;
#(
    parameter int WORD_W_P = WORD_W,
    parameter int ADDR_W_P = ADDR_W,
    parameter int CONV_N   = CONV_SLOTS,
    parameter int THR_N    = THR_SLOTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W_P-1:0]        rd_addr,
    output logic [WORD_W_P-1:0]        rd_word,
    input  logic                       status_rd,
    input  logic                       cmd_en,
    input  logic                       cmd_rst,
    input  logic [3:0]                 cmd_func,
    input  logic                       cmd_prec,
    input  logic                       cmd_stop,
    input  logic                       wr_en,
    input  logic [ADDR_W_P-1:0]        wr_addr,
    input  logic [WORD_W_P-1:0]        wr_data,
    input  logic [CONV_N*WORD_W_P-1:0] conv_bus,
    input  logic [WORD_W_P-1:0]        func_active,
    input  logic [WORD_W_P-1:0]        dav_set,
    input  logic                       pwrdn_stat,
    output logic                       seq_reset,
    output logic                       seq_func_req,
    output logic [3:0]                 seq_func,
    output logic                       next_prec,
    output logic                       seq_sense_chg,
    output logic                       sense_en,
    output logic                       host_mode,
    output logic [12:0]                timing_cfg,
    output logic [WORD_W_P-1:0]        cfg1_word,
    output logic [1:0]                 pin_func,
    output logic [13:0]                filter_cfg
);
    localparam int SLOT_N = 8;

    logic                do_rst;
    logic                host_q, sense_q, prec_q;
    logic [12:0]         timing_q;
    logic [WORD_W_P-1:0] cfg1_q;
    logic [1:0]          pin_q;
    logic [13:0]         filter_q;
    logic [3:0]          func_q;
    logic [WORD_W_P-1:0] dav_q;
    logic                seen_q;
    logic                rst_p_q, req_p_q, chg_p_q;
    logic [WORD_W_P-1:0] thr_q [THR_N];
    logic [WORD_W_P-1:0] conv_w [SLOT_N];
    logic [WORD_W_P-1:0] status_w;

    assign do_rst = cmd_en && cmd_rst;

    // Unpack the conversion result bus; the unused slot reads zero
    for (genvar s = 0; s < SLOT_N; s++) begin : g_conv
        if (s < CONV_N) begin : g_used
            assign conv_w[s] = conv_bus[s*WORD_W_P +: WORD_W_P];
        end else begin : g_unused
            assign conv_w[s] = '0;
        end
    end

    // Limit registers; even slots are high limits
    for (genvar t = 0; t < THR_N; t++) begin : g_thr
        localparam logic [ADDR_W_P-1:0] MY_ADDR = A_THR0 + ADDR_W_P'(t);
        localparam logic [WORD_W_P-1:0] MY_DEF  = (t % 2 == 0) ? THR_HI_DEF : THR_LO_DEF;
        // Hold one limit word
        always_ff @(posedge clk) begin
            if (!rst_n || do_rst)                   thr_q[t] <= MY_DEF;
            else if (wr_en && wr_addr == MY_ADDR)   thr_q[t] <= wr_data;
        end
    end

    // Status word assembly
    always_comb begin
        status_w    = dav_q;
        status_w[7] = dav_q[7] | seen_q;
        status_w[2] = dav_q[2] | pwrdn_stat;
    end

    // Read word selection
    always_comb begin
        case (rd_addr)
            A_STATUS: rd_word = status_w;
            A_CFG0:   rd_word = {host_q, !sense_q, prec_q, timing_q};
            A_CFG1:   rd_word = cfg1_q;
            A_CFG2:   rd_word = {pin_q, filter_q};
            A_FUNC:   rd_word = func_active;
            default: begin
                if (rd_addr < A_STATUS)  rd_word = conv_w[rd_addr[2:0]];
                else                     rd_word = thr_q[rd_addr[1:0]];
            end
        endcase
    end

    // Configuration words and command fields
    always_ff @(posedge clk) begin
        if (!rst_n || do_rst) begin
            host_q   <= 1'b0;
            sense_q  <= 1'b0;
            prec_q   <= 1'b0;
            timing_q <= '0;
            cfg1_q   <= '0;
            pin_q    <= '0;
            filter_q <= '0;
            func_q   <= '0;
        end else if (cmd_en) begin
            func_q  <= cmd_func;
            prec_q  <= cmd_prec;
            sense_q <= !cmd_stop;
        end else if (wr_en) begin
            case (wr_addr)
                A_CFG0: begin
                    host_q   <= wr_data[15];
                    sense_q  <= !wr_data[14];
                    prec_q   <= wr_data[13];
                    timing_q <= wr_data[12:0];
                end
                A_CFG1:  cfg1_q <= wr_data & CFG1_MASK;
                A_CFG2: begin
                    pin_q    <= wr_data[15:14];
                    filter_q <= wr_data[13:0];
                end
                default: ;
            endcase
        end
    end

    // Flags and reset-seen; new flag sets win over the status-read clear
    always_ff @(posedge clk) begin
        if (!rst_n || do_rst) begin
            dav_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            dav_q <= (status_rd ? (dav_q & ~TEST_FLAGS) : dav_q) | dav_set;
            if (status_rd) seen_q <= 1'b1;
        end
    end

    // One-cycle pulses toward the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_p_q <= 1'b0;
            req_p_q <= 1'b0;
            chg_p_q <= 1'b0;
        end else begin
            rst_p_q <= do_rst;
            req_p_q <= cmd_en && !cmd_rst;
            chg_p_q <= (cmd_en && !cmd_rst && (!cmd_stop != sense_q)) ||
                       (wr_en && wr_addr == A_CFG0 && (!wr_data[14] != sense_q));
        end
    end

    assign seq_reset     = rst_p_q;
    assign seq_func_req  = req_p_q;
    assign seq_func      = func_q;
    assign next_prec     = prec_q;
    assign seq_sense_chg = chg_p_q;
    assign sense_en      = sense_q;
    assign host_mode     = host_q;
    assign timing_cfg    = timing_q;
    assign cfg1_word     = cfg1_q;
    assign pin_func      = pin_q;
    assign filter_cfg    = filter_q;

    // R12: a raised flag is present after the edge unless a reset command hit
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((dav_set != '0) && !do_rst) |=> ((dav_q & $past(dav_set)) == $past(dav_set)));
    // R11: a status read marks reset-seen
    a_r11_seen_set: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !do_rst) |=> seen_q);
    // R10: writes to read-only addresses leave configuration untouched
    a_r10_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr <= A_STATUS || wr_addr == A_FUNC))
        |=> $stable({host_q, sense_q, prec_q, timing_q, cfg1_q, pin_q, filter_q}));
    // R2: a reset pulse is never paired with a function request
    a_r2_reset_excl: assert property (@(posedge clk) disable iff (!rst_n)
        seq_reset |-> !seq_func_req);
endmodule

// File: rtl/touch_serial_decoder.sv
// Top of the touch serial decoder: frame tracking plus register bank.
// Assumes one rx_valid per received byte from an external shifter, and a
// sequencer that consumes the one-cycle pulses.
module touch_serial_decoder
    import tsd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_byte,
    output logic [7:0]                   tx_byte,
    input  logic [CONV_SLOTS*WORD_W-1:0] conv_bus,
    input  logic [WORD_W-1:0]            func_active,
    input  logic [WORD_W-1:0]            dav_set,
    input  logic                         pwrdn_stat,
    output logic                         seq_reset,
    output logic                         seq_func_req,
    output logic [3:0]                   seq_func,
    output logic                         next_prec,
    output logic                         seq_sense_chg,
    output logic                         sense_en,
    output logic                         host_mode,
    output logic [12:0]                  timing_cfg,
    output logic [WORD_W-1:0]            cfg1_word,
    output logic [1:0]                   pin_func,
    output logic [13:0]                  filter_cfg,
    output logic                         pd_ctrl
);
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] rd_word, wr_data;
    logic              status_rd, cmd_en, cmd_rst, cmd_prec, cmd_stop, wr_en;
    logic [3:0]        cmd_func;

    tsd_frame_ctrl u_frame (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_word(rd_word), .rd_addr(rd_addr), .status_rd(status_rd),
        .cmd_en(cmd_en), .cmd_rst(cmd_rst), .cmd_func(cmd_func),
        .cmd_prec(cmd_prec), .cmd_stop(cmd_stop), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .tx_byte(tx_byte),
        .pd_ctrl(pd_ctrl)
    );

    tsd_regbank u_regs (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_word(rd_word),
        .status_rd(status_rd), .cmd_en(cmd_en), .cmd_rst(cmd_rst),
        .cmd_func(cmd_func), .cmd_prec(cmd_prec), .cmd_stop(cmd_stop),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .conv_bus(conv_bus), .func_active(func_active), .dav_set(dav_set),
        .pwrdn_stat(pwrdn_stat), .seq_reset(seq_reset),
        .seq_func_req(seq_func_req), .seq_func(seq_func),
        .next_prec(next_prec), .seq_sense_chg(seq_sense_chg),
        .sense_en(sense_en), .host_mode(host_mode), .timing_cfg(timing_cfg),
        .cfg1_word(cfg1_word), .pin_func(pin_func), .filter_cfg(filter_cfg)
    );
endmodule

// File: tb/tb_touch_serial_decoder.sv
// Scoreboard bench: the byte driver queues the expected reply byte, a monitor
// compares it one time unit after each strobe edge.
module tb_touch_serial_decoder;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_valid = 1'b0;
    logic [7:0]   rx_byte = 8'h00;
    logic [7:0]   tx_byte;
    logic [111:0] conv_bus;
    logic [15:0]  func_active = 16'h0000;
    logic [15:0]  dav_set = 16'h0000;
    logic         pwrdn_stat = 1'b0;
    logic         seq_reset, seq_func_req, next_prec, seq_sense_chg;
    logic         sense_en, host_mode, pd_ctrl;
    logic [3:0]   seq_func;
    logic [12:0]  timing_cfg;
    logic [15:0]  cfg1_word;
    logic [1:0]   pin_func;
    logic [13:0]  filter_cfg;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    touch_serial_decoder dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare the reply byte after every strobe edge
    always @(posedge clk) begin
        if (rx_valid) begin
            #1;
            if (exp_q.size() == 0) check(32'h1, 32'h0, "scoreboard underflow");
            else check({24'h0, tx_byte}, {24'h0, exp_q.pop_front()}, tag_q.pop_front());
        end
    end

    // Driver: one byte strobe; returns 2 units after the strobe edge
    task automatic xfer(input logic [7:0] b, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk);
        #2;
        rx_valid = 1'b0;
        rx_byte  = 8'h00;
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [15:0] exp, input string tag,
                          input logic pd = 1'b0);
        xfer({1'b0, a, 1'b0, pd, 1'b1}, exp[15:8], tag);
        xfer(8'h00, exp[7:0], tag);
        xfer(8'h00, 8'h00, tag);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d, input string tag);
        xfer({1'b0, a, 3'b000}, 8'h00, tag);
        xfer(d[15:8], 8'h00, tag);
        xfer(d[7:0], 8'h00, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 7; i++) conv_bus[i*16 +: 16] = 16'hA000 + 16'(i * 16'h0101);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2 reset state, R3 idle reply
        check(tx_byte, 8'h00, "R3 idle reply after reset");
        check(sense_en, 1'b0, "R2 sense off after reset");
        check({seq_reset, seq_func_req, seq_sense_chg}, 3'b000, "R2 no pulses after reset");
        rd_reg(4'h8, 16'h0FFF, "R9 aux high default");
        rd_reg(4'h9, 16'h0000, "R9 aux low default");
        rd_reg(4'hA, 16'h0FFF, "R9 temp high default");
        rd_reg(4'hC, 16'h4000, "R6 cfg0 default");

        // R3: zero byte ignored, next byte is still a header
        xfer(8'h00, 8'h00, "R3 zero byte");
        rd_reg(4'hB, 16'h0000, "R3 frame after zero byte");

        // R1: command function 5, precision 1, sensing on
        xfer(8'hAC, 8'h00, "R1 command reply");
        check({seq_func_req, seq_func, next_prec}, {1'b1, 4'h5, 1'b1}, "R1 function request");
        check({seq_sense_chg, sense_en}, 2'b11, "R1 sense change");
        check(seq_reset, 1'b0, "R1 no reset pulse");
        rd_reg(4'hC, 16'h2000, "R6 cfg0 after command");
        xfer(8'hAC, 8'h00, "R1 repeat command");
        check({seq_func_req, seq_sense_chg}, 2'b10, "R1 no change pulse when same");

        // R5/R6: cfg0 write commits at third byte
        xfer(8'h60, 8'h00, "R5 write header");
        xfer(8'hC1, 8'h00, "R5 high byte");
        check({host_mode, timing_cfg}, {1'b0, 13'h0000}, "R5 no commit after second byte");
        xfer(8'h23, 8'h00, "R5 low byte");
        check({host_mode, sense_en, next_prec, timing_cfg}, {1'b1, 1'b0, 1'b0, 13'h0123},
              "R6 cfg0 fields");
        check(seq_sense_chg, 1'b1, "R6 sense change on write");
        rd_reg(4'hC, 16'hC123, "R6 cfg0 readback");

        // R7, R8, R9
        wr_reg(4'hD, 16'hFFFF, "R7 write");
        check(cfg1_word, 16'h0F07, "R7 mask");
        rd_reg(4'hD, 16'h0F07, "R7 readback");
        wr_reg(4'hE, 16'h8005, "R8 write");
        check({pin_func, filter_cfg}, {2'b10, 14'h0005}, "R8 fields");
        rd_reg(4'hE, 16'h8005, "R8 readback");
        wr_reg(4'h8, 16'h0ABC, "R9 write");
        wr_reg(4'hB, 16'h1234, "R9 write");
        rd_reg(4'h8, 16'h0ABC, "R9 readback aux high");
        rd_reg(4'hB, 16'h1234, "R9 readback temp low");

        // R10, R13: read-only addresses
        func_active = 16'h0020;
        wr_reg(4'h3, 16'hFFFF, "R10 write 0x3");
        wr_reg(4'hF, 16'hFFFF, "R10 write 0xF");
        rd_reg(4'h3, 16'hA303, "R13 slot 3 after write");
        rd_reg(4'h0, 16'hA000, "R13 slot 0");
        rd_reg(4'hF, 16'h0020, "R13 function flags");
        rd_reg(4'hC, 16'hC123, "R10 cfg0 untouched");

        // R11: status read side effects
        pwrdn_stat = 1'b1;
        @(negedge clk) dav_set = 16'h00E1;
        @(negedge clk) dav_set = 16'h0000;
        rd_reg(4'h7, 16'h00E5, "R11 first status");
        rd_reg(4'h7, 16'h0085, "R11 second status");

        // R12: flag set during the clearing read wins
        dav_set = 16'h0040;
        xfer(8'h39, 8'h00, "R12 status header");
        dav_set = 16'h0000;
        xfer(8'h00, 8'h85, "R12 status low byte");
        xfer(8'h00, 8'h00, "R12 status end");
        rd_reg(4'h7, 16'h00C5, "R12 flag kept");
        rd_reg(4'h7, 16'h0085, "R12 flag cleared by later read");

        // R14: power-down control bit
        rd_reg(4'h9, 16'h0000, "R14 read with pd", 1'b1);
        check(pd_ctrl, 1'b1, "R14 pd set");
        rd_reg(4'h9, 16'h0000, "R14 read without pd", 1'b0);
        check(pd_ctrl, 1'b0, "R14 pd clear");

        // R2: reset command
        xfer(8'h82, 8'h00, "R2 reset command");
        check({seq_reset, seq_func_req}, 2'b10, "R2 reset pulse");
        check({sense_en, host_mode, cfg1_word}, {2'b00, 16'h0000}, "R2 config cleared");
        rd_reg(4'h8, 16'h0FFF, "R2 aux high restored");
        rd_reg(4'h7, 16'h0004, "R2 status cleared");

        // R2: hardware reset mid-frame
        xfer(8'h41, 8'h0F, "R2 header before reset");
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check(tx_byte, 8'h00, "R2 reply zero after reset");
        rd_reg(4'h9, 16'h0000, "R2 frame after reset");

        repeat (3) @(negedge clk);
        check(exp_q.size(), 0, "scoreboard drained");
        finish_run();
    end
endmodule